// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is the master end of a two-wire station-management bus. It divides the system clock down to make the management clock. It drives, releases and samples the shared data line through a separate output value, an output enable and a synchronized input. A host issues one register access at a time on a small command interface. It pulses `cmd_start` with the direction, the addressing style, the PHY address, the register or device field, an optional 16-bit register address and the write data. `busy` stays high until a one-cycle `done` pulse returns the result.

Short-form (Clause 22) accesses are a single frame. Extended (Clause 45) accesses are sent on their own as a pair of frames: first an address frame that carries the 16-bit register address, then a read or write frame to the same device. On every read the master checks the turnaround bit that the PHY should drive low. When that bit is wrong, the master clears the bus with dummy clocks and reports an error, unless the per-PHY ignore mask excuses that PHY.

Top module: `mdio_master`

## Requirements
- R1: After reset, and until the first accepted command, `mdc`, `mdio_oe`, `busy` and `done` are all low.
- R2: Every frame opens with 32 rising `mdc` edges at which `mdio_oe`=1 and `mdio_o`=1.
- R3: A short-form frame sends, after the preamble and MSB first: start bits 0,1; opcode 1,0 for read or 0,1 for write; `cmd_phy` (5 bits); `cmd_dev` as register number (5 bits).
- R4: Write and address frames then drive turnaround 1,0 and 16 data bits MSB first. They release the line (`mdio_oe`=0) for one more `mdc` cycle, so the frame has 65 rising edges.
- R5: A read frame releases the line directly after the 5-bit register field and samples one turnaround bit. When that bit is 0, it samples 16 data bits MSB first and clocks one released cycle (64 edges). It then returns them on `rd_data` with `ta_err`=0.
- R6: If a read samples turnaround 1 and `ta_mask[cmd_phy]` is 0, the master clocks 32 more released cycles (79 edges in the frame) and discards them. It then returns `rd_data`=16'hFFFF with `ta_err`=1.
- R7: If `ta_mask[cmd_phy]` is 1, a turnaround of 1 is accepted and the read completes as in R5.
- R8: With `cmd_c45`=1 the master sends an address frame (start 0,0, opcode 0,0, device `cmd_dev`, data `cmd_addr`). It follows it with a frame with start 0,0 and opcode 1,1 (read) or 0,1 (write) to the same PHY and device, carrying `cmd_wdata` on writes.
- R9: `mdio_o` and `mdio_oe` change only while `mdc` is low. `mdc` stays high for HALF_DIV clocks on driven bits and RD_HIGH clocks on released bits. It stays low for at least HALF_DIV+1 clocks, and the input is sampled as `mdc` falls.
- R10: `cmd_start` while `busy` is high is ignored and does not alter the access in progress.
- R11: `done` is a single-cycle pulse, raised only with `busy` low, once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, taken only while idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_c45 | input | 1 | 1 = extended (address + data frame) access |
| cmd_phy | input | 5 | PHY address |
| cmd_dev | input | 5 | Register number (short form) or device number (extended) |
| cmd_addr | input | 16 | Register address for extended accesses |
| cmd_wdata | input | 16 | Write data |
| ta_mask | input | 32 | Per-PHY enable for ignoring a bad turnaround |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, held until next start |
| ta_err | output | 1 | Turnaround error on the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value to the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_i | input | 1 | Data value from the pad |

## Verification
The assertions take for granted two things. First, the PHY changes `mdio_i` only shortly after a rising `mdc` and holds it until `mdc` falls. Second, RD_HIGH is at least HALF_DIV and leaves three or more clocks for the two-flop synchronizer. The bench's PHY model changes its line only at the rising `mdc` edge, from a per-edge response table. It keeps RD_HIGH at six clocks, so every sample lands well after the synchronizer has settled. Command fields are held steady only around the start pulse. Stray start pulses during busy carry deliberately different fields, to show that they are never sampled.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W      = 5;
  localparam int FLD_W      = 5;
  localparam int DAT_W      = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 4 + PHY_W + FLD_W;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + 2 + DAT_W;
  localparam int RDOUT_BITS = PRE_BITS + HDR_BITS;
  localparam int FLUSH_BITS = 32;
  localparam int REM_W      = $clog2(FRAME_BITS + 1);

  localparam logic [1:0] OP_SF_RD  = 2'b10;
  localparam logic [1:0] OP_SF_WR  = 2'b01;
  localparam logic [1:0] OP_EX_ADR = 2'b00;
  localparam logic [1:0] OP_EX_RD  = 2'b11;
  localparam logic [1:0] OP_EX_WR  = 2'b01;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_OUT, SQ_TA, SQ_RD, SQ_FLUSH, SQ_TAIL
  } seq_st_e;

  typedef enum logic [1:0] {
    TM_IDLE, TM_LOW, TM_HIGH
  } tim_st_e;

  // Whole driven frame: preamble, start, opcode, two address fields,
  // turnaround and data. Shifted out from the MSB.
  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic             ext,
    input logic [1:0]       op,
    input logic [PHY_W-1:0] phy,
    input logic [FLD_W-1:0] fld,
    input logic [DAT_W-1:0] dat
  );
    return {{PRE_BITS{1'b1}}, 1'b0, ~ext, op, phy, fld, 2'b10, dat};
  endfunction

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_VAL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 50,
  parameter int RD_HIGH  = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_go,
  input  logic bit_long,
  output logic mdc,
  output logic bit_end
);

  localparam int MAXC = (RD_HIGH > HALF_DIV) ? RD_HIGH : HALF_DIV;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LO_LIM = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] HS_LIM = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] HL_LIM = CW'(RD_HIGH - 1);

  tim_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;
  logic          mdc_q, mdc_d;
  logic          end_q, end_d;
  logic [CW-1:0] hi_lim;

  assign hi_lim = long_q ? HL_LIM : HS_LIM;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    long_d = long_q;
    mdc_d  = mdc_q;
    end_d  = 1'b0;
    case (st_q)
      TM_IDLE: begin
        if (bit_go) begin
          st_d   = TM_LOW;
          cnt_d  = '0;
          long_d = bit_long;
        end
      end
      TM_LOW: begin
        if (cnt_q == LO_LIM) begin
          st_d  = TM_HIGH;
          cnt_d = '0;
          mdc_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      TM_HIGH: begin
        if (cnt_q == hi_lim) begin
          st_d  = TM_IDLE;
          cnt_d = '0;
          mdc_d = 1'b0;
          end_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = TM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TM_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
      mdc_q  <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      long_q <= long_d;
      mdc_q  <= mdc_d;
      end_q  <= end_d;
    end
  end

  assign mdc     = mdc_q;
  assign bit_end = end_q;

  // Checker: length of each high phase of the management clock.
  logic [CW:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (mdc_q) hi_run_q <= hi_run_q + 1'b1;
    else            hi_run_q <= '0;
  end

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc_q) |-> (hi_run_q == (CW+1)'(HALF_DIV) || hi_run_q == (CW+1)'(RD_HIGH))); // R9
  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_go |-> (st_q == TM_IDLE && !mdc_q)); // R9
  AST_END_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> !mdc); // R9

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_write,
  input  logic             cmd_c45,
  input  logic [PHY_W-1:0] cmd_phy,
  input  logic [FLD_W-1:0] cmd_dev,
  input  logic [DAT_W-1:0] cmd_addr,
  input  logic [DAT_W-1:0] cmd_wdata,
  input  logic [31:0]      ta_mask,
  input  logic             bit_end,
  input  logic             din,
  output logic             bit_go,
  output logic             bit_long,
  output logic             mdo,
  output logic             mdo_en,
  output logic             busy,
  output logic             done,
  output logic [DAT_W-1:0] rd_data,
  output logic             ta_err
);

  seq_st_e               st_q, st_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [REM_W-1:0]      rem_q, rem_d;
  logic [DAT_W-1:0]      rx_q, rx_d;
  logic                  go_q, go_d;
  logic                  long_q, long_d;
  logic                  oe_q, oe_d;
  logic                  aph_q, aph_d;
  logic                  rfr_q, rfr_d;
  logic                  wr_q, wr_d;
  logic [PHY_W-1:0]      phy_q, phy_d;
  logic [FLD_W-1:0]      dev_q, dev_d;
  logic [DAT_W-1:0]      wd_q, wd_d;
  logic                  done_q, done_d;
  logic [DAT_W-1:0]      rdat_q, rdat_d;
  logic                  err_q, err_d;
  logic                  ta_ok;

  assign ta_ok = (din == 1'b0) || ta_mask[phy_q];

  always_comb begin
    st_d   = st_q;
    tx_d   = tx_q;
    rem_d  = rem_q;
    rx_d   = rx_q;
    go_d   = 1'b0;
    long_d = long_q;
    oe_d   = oe_q;
    aph_d  = aph_q;
    rfr_d  = rfr_q;
    wr_d   = wr_q;
    phy_d  = phy_q;
    dev_d  = dev_q;
    wd_d   = wd_q;
    done_d = 1'b0;
    rdat_d = rdat_q;
    err_d  = err_q;
    case (st_q)
      SQ_IDLE: begin
        if (cmd_start) begin
          wr_d   = cmd_write;
          phy_d  = cmd_phy;
          dev_d  = cmd_dev;
          wd_d   = cmd_wdata;
          err_d  = 1'b0;
          aph_d  = cmd_c45;
          oe_d   = 1'b1;
          go_d   = 1'b1;
          long_d = 1'b0;
          st_d   = SQ_OUT;
          if (cmd_c45) begin
            tx_d  = build_frame(1'b1, OP_EX_ADR, cmd_phy, cmd_dev, cmd_addr);
            rfr_d = 1'b0;
            rem_d = REM_W'(FRAME_BITS);
          end else begin
            tx_d  = build_frame(1'b0, cmd_write ? OP_SF_WR : OP_SF_RD,
                                cmd_phy, cmd_dev, cmd_wdata);
            rfr_d = !cmd_write;
            rem_d = cmd_write ? REM_W'(FRAME_BITS) : REM_W'(RDOUT_BITS);
          end
        end
      end
      SQ_OUT: begin
        if (bit_end) begin
          go_d = 1'b1;
          if (rem_q == REM_W'(1)) begin
            oe_d   = 1'b0;
            long_d = 1'b1;
            st_d   = rfr_q ? SQ_TA : SQ_TAIL;
          end else begin
            rem_d  = rem_q - 1'b1;
            tx_d   = {tx_q[FRAME_BITS-2:0], 1'b0};
            long_d = 1'b0;
          end
        end
      end
      SQ_TA: begin
        if (bit_end) begin
          go_d   = 1'b1;
          long_d = 1'b1;
          if (ta_ok) begin
            st_d  = SQ_RD;
            rem_d = REM_W'(DAT_W);
          end else begin
            st_d  = SQ_FLUSH;
            rem_d = REM_W'(FLUSH_BITS);
          end
        end
      end
      SQ_RD: begin
        if (bit_end) begin
          rx_d   = {rx_q[DAT_W-2:0], din};
          go_d   = 1'b1;
          long_d = 1'b1;
          if (rem_q == REM_W'(1)) st_d = SQ_TAIL;
          else                    rem_d = rem_q - 1'b1;
        end
      end
      SQ_FLUSH: begin
        if (bit_end) begin
          if (rem_q == REM_W'(1)) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
            rdat_d = '1;
            err_d  = 1'b1;
          end else begin
            rem_d  = rem_q - 1'b1;
            go_d   = 1'b1;
            long_d = 1'b1;
          end
        end
      end
      SQ_TAIL: begin
        if (bit_end) begin
          if (aph_q) begin
            aph_d  = 1'b0;
            tx_d   = build_frame(1'b1, wr_q ? OP_EX_WR : OP_EX_RD, phy_q, dev_q, wd_q);
            rfr_d  = !wr_q;
            rem_d  = wr_q ? REM_W'(FRAME_BITS) : REM_W'(RDOUT_BITS);
            oe_d   = 1'b1;
            go_d   = 1'b1;
            long_d = 1'b0;
            st_d   = SQ_OUT;
          end else begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
            if (rfr_q) rdat_d = rx_q;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      tx_q   <= '0;
      rem_q  <= '0;
      rx_q   <= '0;
      go_q   <= 1'b0;
      long_q <= 1'b0;
      oe_q   <= 1'b0;
      aph_q  <= 1'b0;
      rfr_q  <= 1'b0;
      wr_q   <= 1'b0;
      phy_q  <= '0;
      dev_q  <= '0;
      wd_q   <= '0;
      done_q <= 1'b0;
      rdat_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tx_q   <= tx_d;
      rem_q  <= rem_d;
      rx_q   <= rx_d;
      go_q   <= go_d;
      long_q <= long_d;
      oe_q   <= oe_d;
      aph_q  <= aph_d;
      rfr_q  <= rfr_d;
      wr_q   <= wr_d;
      phy_q  <= phy_d;
      dev_q  <= dev_d;
      wd_q   <= wd_d;
      done_q <= done_d;
      rdat_q <= rdat_d;
      err_q  <= err_d;
    end
  end

  assign bit_go   = go_q;
  assign bit_long = long_q;
  assign mdo      = tx_q[FRAME_BITS-1];
  assign mdo_en   = oe_q;
  assign busy     = (st_q != SQ_IDLE);
  assign done     = done_q;
  assign rd_data  = rdat_q;
  assign ta_err   = err_q;

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_TA || st_q == SQ_RD || st_q == SQ_FLUSH) |-> !oe_q); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == SQ_IDLE)); // R11
  AST_ERR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> (rdat_q == '1)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start) |=> ($stable(phy_q) && $stable(wr_q) && $stable(dev_q))); // R10

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV    = 50,
  parameter int RD_HIGH     = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_write,
  input  logic        cmd_c45,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_dev,
  input  logic [15:0] cmd_addr,
  input  logic [15:0] cmd_wdata,
  input  logic [31:0] ta_mask,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        ta_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic din_s;
  logic bit_go;
  logic bit_long;
  logic bit_end;

  mdio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_i),
    .q     (din_s)
  );

  mdio_bit_timer #(.HALF_DIV(HALF_DIV), .RD_HIGH(RD_HIGH)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_go   (bit_go),
    .bit_long (bit_long),
    .mdc      (mdc),
    .bit_end  (bit_end)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_write (cmd_write),
    .cmd_c45   (cmd_c45),
    .cmd_phy   (cmd_phy),
    .cmd_dev   (cmd_dev),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .ta_mask   (ta_mask),
    .bit_end   (bit_end),
    .din       (din_s),
    .bit_go    (bit_go),
    .bit_long  (bit_long),
    .mdo       (mdio_o),
    .mdo_en    (mdio_oe),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .ta_err    (ta_err)
  );

  AST_PAD_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

  localparam int HD = 4;
  localparam int RH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0, cmd_write = 1'b0, cmd_c45 = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_dev = '0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic [31:0] ta_mask = 32'h0000_00F0;
  logic        busy, done, ta_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_DIV(HD), .RD_HIGH(RH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_c45(cmd_c45), .cmd_phy(cmd_phy), .cmd_dev(cmd_dev), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .ta_mask(ta_mask), .busy(busy), .done(done),
    .rd_data(rd_data), .ta_err(ta_err), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic resp   [0:255];
  logic obs_o  [0:255];
  logic obs_oe [0:255];
  logic exp_o  [0:255];
  logic exp_oe [0:255];
  int   exp_cl [0:255];
  int   k = 0;
  int   n_exp = 0;

  // PHY model: records each rising edge, then presents its bit for it.
  always @(posedge mdc) begin
    if (k < 256) begin
      obs_o[k]  = mdio_o;
      obs_oe[k] = mdio_oe;
      mdio_i    = resp[k];
    end
    k = k + 1;
  end

  // Timing and handshake monitor.
  int  tviol = 0, dviol = 0, hi_len = 0, lo_len = 0, n_fall = 0, n_done = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0, prev_done = 1'b0, rise_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc && !prev_mdc) begin
        if (lo_len < HD + 1) tviol++;
        rise_oe = mdio_oe;
        hi_len = 1;
      end else if (mdc) begin
        hi_len++;
        if (mdio_o != prev_o || mdio_oe != prev_oe) tviol++;
      end else if (!mdc && prev_mdc) begin
        n_fall++;
        if (hi_len != (rise_oe ? HD : RH)) tviol++;
        lo_len = 1;
      end else begin
        lo_len++;
      end
      if (done && (prev_done || busy)) dviol++;
      if (done) n_done++;
    end
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe; prev_done = done;
  end

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic v, input logic oe, input int cl);
    exp_o[n_exp] = v; exp_oe[n_exp] = oe; exp_cl[n_exp] = cl;
    n_exp++;
  endtask

  task automatic add_frame(input logic ext, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] fld, input logic [15:0] dat,
                           input bit rdf, input bit ta_bad, input logic [15:0] rdv);
    logic [13:0] hdr;
    hdr = {1'b0, ~ext, op, phy, fld};
    for (int i = 0; i < 32; i++) push(1'b1, 1'b1, 0);
    for (int i = 13; i >= 0; i--) push(hdr[i], 1'b1, 1);
    if (!rdf) begin
      push(1'b1, 1'b1, 2); push(1'b0, 1'b1, 2);
      for (int i = 15; i >= 0; i--) push(dat[i], 1'b1, 2);
      push(1'b0, 1'b0, 2);
    end else begin
      resp[n_exp] = ta_bad;
      push(1'b0, 1'b0, 2);
      if (ta_bad && !ta_mask[phy]) begin
        for (int i = 0; i < 32; i++) push(1'b0, 1'b0, 2);
      end else begin
        for (int i = 15; i >= 0; i--) begin
          resp[n_exp] = rdv[i];
          push(1'b0, 1'b0, 2);
        end
        push(1'b0, 1'b0, 2);
      end
    end
  endtask

  task automatic run(input bit wr, input bit ext, input logic [4:0] phy, input logic [4:0] dev,
                     input logic [15:0] adr, input logic [15:0] wd, input logic [15:0] rdv,
                     input bit ta_bad, input bit poke);
    string rh, rb;
    int t, m_pre, m_hdr, m_body;
    bit bad_unmasked;
    logic [15:0] got_d;
    logic got_e;
    bad_unmasked = ta_bad && !ta_mask[phy];
    rh = ext ? "R8" : "R3";
    rb = wr ? "R4" : (bad_unmasked ? "R6" : (ta_bad ? "R7" : "R5"));
    for (int i = 0; i < 256; i++) resp[i] = 1'b1;
    n_exp = 0;
    if (ext) begin
      add_frame(1'b1, 2'b00, phy, dev, adr, 1'b0, 1'b0, 16'h0);
      add_frame(1'b1, wr ? 2'b01 : 2'b11, phy, dev, wd, !wr, ta_bad, rdv);
    end else begin
      add_frame(1'b0, wr ? 2'b01 : 2'b10, phy, dev, wd, !wr, ta_bad, rdv);
    end
    k = 0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_write = wr; cmd_c45 = ext; cmd_phy = phy;
    cmd_dev = dev; cmd_addr = adr; cmd_wdata = wd;
    @(negedge clk);
    cmd_start = 1'b0;
    t = 0;
    while (!done && t < 6000) begin
      @(negedge clk);
      t++;
      if (poke && t == 200) begin
        // R10: stray request with different fields while busy
        cmd_start = 1'b1; cmd_write = ~wr; cmd_c45 = ~ext; cmd_phy = ~phy; cmd_dev = ~dev;
        cmd_wdata = ~wd;
        @(negedge clk);
        cmd_start = 1'b0;
        t++;
      end
    end
    got_d = rd_data; got_e = ta_err;
    chk(rb, "done seen", done, 1);
    repeat (30) @(negedge clk);
    chk(poke ? "R10" : rb, "mdc edges", k, n_exp);
    m_pre = 0; m_hdr = 0; m_body = 0;
    for (int i = 0; i < n_exp && i < k && i < 256; i++) begin
      if (obs_oe[i] != exp_oe[i] || (exp_oe[i] && obs_o[i] != exp_o[i])) begin
        if (exp_cl[i] == 0) m_pre++;
        else if (exp_cl[i] == 1) m_hdr++;
        else m_body++;
      end
    end
    chk("R2", "preamble bit mismatches", m_pre, 0);
    chk(rh, "header bit mismatches", m_hdr, 0);
    chk(poke ? "R10" : rb, "body bit mismatches", m_body, 0);
    if (!wr) begin
      chk(rb, "rd_data", got_d, bad_unmasked ? 16'hFFFF : rdv);
      chk(rb, "ta_err", got_e, bad_unmasked);
    end
    chk("R11", "busy after done", busy, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [4:0]  phy, dev;
    logic [15:0] dat;
    int done_before;
    repeat (4) @(negedge clk);
    chk("R1", "mdc in reset", mdc, 0);
    chk("R1", "oe in reset", mdio_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "mdc after reset", mdc, 0);
    chk("R1", "oe after reset", mdio_oe, 0);

    // Short-form sweep: addresses span both ends, data patterns vary.
    for (int i = 0; i < 8; i++) begin
      phy = 5'((i * 31) / 7);
      dev = 5'(31 - i * 4);
      dat = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (i == 2) ? 16'h8001 :
            16'((16'hA5C3 ^ (i * 16'h1111)) + i);
      run(1'b1, 1'b0, phy, dev, 16'h0, dat, 16'h0, 1'b0, 1'b0);
      run(1'b0, 1'b0, phy, dev, 16'h0, 16'h0, ~dat, 1'b0, 1'b0);
    end

    // Turnaround handling: unmasked (R6) and masked (R7) PHYs.
    run(1'b0, 1'b0, 5'd3,  5'd1,  16'h0, 16'h0, 16'h1234, 1'b1, 1'b0);
    run(1'b0, 1'b0, 5'd31, 5'd7,  16'h0, 16'h0, 16'h00FF, 1'b1, 1'b0);
    run(1'b0, 1'b0, 5'd5,  5'd2,  16'h0, 16'h0, 16'hBEEF, 1'b1, 1'b0);
    run(1'b0, 1'b0, 5'd7,  5'd30, 16'h0, 16'h0, 16'h0001, 1'b1, 1'b0);
    // Good read follows an error: error flag clears (R5)
    run(1'b0, 1'b0, 5'd3,  5'd1,  16'h0, 16'h0, 16'h4321, 1'b0, 1'b0);

    // Extended accesses (R8)
    for (int i = 0; i < 4; i++) begin
      phy = 5'(i * 10 + 1);
      dev = 5'(i * 7 + 3);
      run(1'b1, 1'b1, phy, dev, 16'(16'hF00D ^ (i << 5)), 16'(16'h3C3C + i), 16'h0, 1'b0, 1'b0);
      run(1'b0, 1'b1, phy, dev, 16'(16'h0F0F + i), 16'h0, 16'(16'h9A00 | i), 1'b0, 1'b0);
    end
    run(1'b0, 1'b1, 5'd2, 5'd31, 16'hFFFF, 16'h0, 16'h5555, 1'b1, 1'b0);
    run(1'b0, 1'b1, 5'd6, 5'd0,  16'h0000, 16'h0, 16'hAAAA, 1'b1, 1'b0);

    // Start while busy is ignored (R10)
    done_before = n_done;
    run(1'b1, 1'b0, 5'd9,  5'd12, 16'h0, 16'hC0DE, 16'h0, 1'b0, 1'b1);
    run(1'b0, 1'b0, 5'd20, 5'd17, 16'h0, 16'h0, 16'h7E57, 1'b0, 1'b1);
    chk("R10", "done pulses for two poked accesses", n_done - done_before, 2);

    chk("R9", "timing violations", tviol, 0);
    chk("R9", "mdc cycles observed nonzero", (n_fall > 1000), 1);
    chk("R11", "done pulse violations", dviol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule